// File: doc/BRIEF.md
# Branch and Jump Target Unit

This block produces the next program counter for the control-flow instructions of a 32-bit RISC core. It holds the current PC in a register that resets to zero. From that PC, a decoded control code, the raw offset field of the instruction, a source register value and a register-test operand, it works out the address of the next instruction, whether control is transferred, and what a linking call must write into the register file.

Two kinds of target are supported. A PC-relative target is measured from PC+4: conditional branches use a 16-bit signed byte offset and jumps use a 26-bit signed byte offset. A register-indirect target is taken from a general-purpose register. A subroutine return is written as a register-indirect jump through the link register. Linking calls always name register 31 and write it with PC+4.

All outputs are combinational from the inputs and the held PC. The fetch stage asserts `step_i` to load the computed next PC into the PC register.

Top module: `br_target_unit`

## Requirements
- R1: After `rst_ni` is asserted low, `pc_o` reads 0.
- R2: At a rising clock edge with `step_i` high, `pc_o` takes the value `next_pc_o` had before the edge. With `step_i` low, `pc_o` keeps its value.
- R3: With `ctl_i`=1 (branch if zero), the branch is taken only when `test_val_i` is 0. When taken, `next_pc_o` = PC+4 + sign-extended `off_i[15:0]` and `taken_o`=1. Bits 25:16 of `off_i` are ignored.
- R4: With `ctl_i`=2 (branch if nonzero), the branch is taken only when `test_val_i` is not 0, with the same target as R3.
- R5: With `ctl_i`=0 (sequential), code 7 (reserved), or a conditional branch that is not taken, `next_pc_o` = PC+4, and `taken_o` and `link_we_o` are 0.
- R6: With `ctl_i`=3 (jump), `next_pc_o` = PC+4 + sign-extended `off_i[25:0]`, `taken_o`=1 and `link_we_o`=0.
- R7: With `ctl_i`=4 (jump and link), the target is the same as R6, and in addition `link_we_o`=1, `link_idx_o`=31 and `link_val_o`=PC+4.
- R8: With `ctl_i`=5 (jump register) and `rs_val_i[1:0]`=0, `next_pc_o` = `rs_val_i`, `taken_o`=1 and `link_we_o`=0.
- R9: With `ctl_i`=6 (jump and link register) and an aligned `rs_val_i`, the target is the same as R8, with `link_we_o`=1, `link_idx_o`=31 and `link_val_o`=PC+4.
- R10: For codes 5 and 6 with `rs_val_i[1:0]` not 0, `misalign_o`=1, `next_pc_o` = PC, and `taken_o` and `link_we_o` are 0. For every other case `misalign_o` is 0.
- R11: PC-relative targets reach the extreme offsets −2^25 and 2^25−1 from PC+4. All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Load the next PC into the PC register |
| ctl_i | input | 3 | Control code: 0 seq, 1 beqz, 2 bnez, 3 j, 4 jal, 5 jr, 6 jalr, 7 reserved |
| off_i | input | 26 | Raw offset field of the instruction |
| rs_val_i | input | 32 | Register-indirect target value |
| test_val_i | input | 32 | Operand tested against zero |
| pc_o | output | 32 | Current PC |
| next_pc_o | output | 32 | Next PC |
| taken_o | output | 1 | Control transfer taken |
| misalign_o | output | 1 | Register target not word aligned |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index (31) |
| link_val_o | output | 32 | Link value, PC+4 |

## Verification
The branch tests use both a zero and a nonzero operand, including an operand where only the top bit is set. This shows that every bit takes part in the zero test. The branch offsets are chosen with the sign bit both set and clear, and with junk in the upper field bits, which exposes a wrong extension width. The jumps use the two extreme 26-bit offsets and a PC near the top of the address space, which separates correct 26-bit sign extension and wraparound from truncation. The register targets are tried with each of the nonzero low-bit patterns, and the PC is stepped in between. This shows that a misaligned target holds the PC, while an aligned one moves it and writes the link only for the linking forms.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    CT_SEQ  = 3'd0,
    CT_BEQZ = 3'd1,
    CT_BNEZ = 3'd2,
    CT_J    = 3'd3,
    CT_JAL  = 3'd4,
    CT_JR   = 3'd5,
    CT_JALR = 3'd6,
    CT_RSV  = 3'd7
  } ctl_e;
endpackage

// File: rtl/bt_decode.sv
module bt_decode
  import bt_pkg::*;
(
  input  ctl_e ctl_i,
  input  logic test_zero_i,
  output logic is_cond_o,
  output logic cond_take_o,
  output logic is_jrel_o,
  output logic is_jreg_o,
  output logic is_link_o
);
  always_comb begin
    is_cond_o   = 1'b0;
    cond_take_o = 1'b0;
    is_jrel_o   = 1'b0;
    is_jreg_o   = 1'b0;
    is_link_o   = 1'b0;
    unique case (ctl_i)
      CT_BEQZ: begin is_cond_o = 1'b1; cond_take_o = test_zero_i;  end
      CT_BNEZ: begin is_cond_o = 1'b1; cond_take_o = !test_zero_i; end
      CT_J:    is_jrel_o = 1'b1;
      CT_JAL:  begin is_jrel_o = 1'b1; is_link_o = 1'b1; end
      CT_JR:   is_jreg_o = 1'b1;
      CT_JALR: begin is_jreg_o = 1'b1; is_link_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/bt_target.sv
module bt_target #(
  parameter int XLEN       = 32,
  parameter int BR_OFF_W   = 16,
  parameter int J_OFF_W    = 26,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0]    pc_plus_i,
  input  logic [J_OFF_W-1:0] off_i,
  input  logic [XLEN-1:0]    rs_val_i,
  output logic [XLEN-1:0]    br_tgt_o,
  output logic [XLEN-1:0]    j_tgt_o,
  output logic               misalign_o
);
  localparam int ALIGN_W = $clog2(INSN_BYTES);

  logic [XLEN-1:0] br_sext, j_sext;

  assign br_sext  = {{(XLEN-BR_OFF_W){off_i[BR_OFF_W-1]}}, off_i[BR_OFF_W-1:0]};
  assign j_sext   = {{(XLEN-J_OFF_W){off_i[J_OFF_W-1]}}, off_i};
  assign br_tgt_o = pc_plus_i + br_sext;
  assign j_tgt_o  = pc_plus_i + j_sext;

  generate
    if (ALIGN_W == 0) begin : g_no_align
      assign misalign_o = 1'b0;
    end else begin : g_align
      assign misalign_o = |rs_val_i[ALIGN_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/bt_pc_reg.sv
module bt_pc_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [XLEN-1:0] nxt_i,
  output logic [XLEN-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_o <= '0;
    else if (step_i) pc_o <= nxt_i;
  end

  AST_PC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> pc_o == $past(nxt_i)); // R2
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o)); // R2
endmodule

// File: rtl/br_target_unit.sv
module br_target_unit
  import bt_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int BR_OFF_W   = 16,
  parameter int J_OFF_W    = 26,
  parameter int INSN_BYTES = 4,
  parameter int REG_IDX_W  = 5,
  parameter int LINK_REG   = 31
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic [2:0]           ctl_i,
  input  logic [J_OFF_W-1:0]   off_i,
  input  logic [XLEN-1:0]      rs_val_i,
  input  logic [XLEN-1:0]      test_val_i,
  output logic [XLEN-1:0]      pc_o,
  output logic [XLEN-1:0]      next_pc_o,
  output logic                 taken_o,
  output logic                 misalign_o,
  output logic                 link_we_o,
  output logic [REG_IDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]      link_val_o
);
  localparam logic [XLEN-1:0] STEP_BYTES = XLEN'(INSN_BYTES);

  ctl_e            ctl;
  logic            is_cond, cond_take, is_jrel, is_jreg, is_link;
  logic [XLEN-1:0] pc_q, pc_plus, br_tgt, j_tgt, nxt;
  logic            reg_misalign;

  assign ctl     = ctl_e'(ctl_i);
  assign pc_plus = pc_q + STEP_BYTES;

  bt_decode u_dec (
    .ctl_i       (ctl),
    .test_zero_i (test_val_i == '0),
    .is_cond_o   (is_cond),
    .cond_take_o (cond_take),
    .is_jrel_o   (is_jrel),
    .is_jreg_o   (is_jreg),
    .is_link_o   (is_link)
  );

  bt_target #(
    .XLEN(XLEN), .BR_OFF_W(BR_OFF_W), .J_OFF_W(J_OFF_W), .INSN_BYTES(INSN_BYTES)
  ) u_tgt (
    .pc_plus_i  (pc_plus),
    .off_i      (off_i),
    .rs_val_i   (rs_val_i),
    .br_tgt_o   (br_tgt),
    .j_tgt_o    (j_tgt),
    .misalign_o (reg_misalign)
  );

  always_comb begin
    nxt       = pc_plus;
    taken_o   = 1'b0;
    link_we_o = 1'b0;
    if (is_cond && cond_take) begin
      nxt     = br_tgt;
      taken_o = 1'b1;
    end else if (is_jrel) begin
      nxt       = j_tgt;
      taken_o   = 1'b1;
      link_we_o = is_link;
    end else if (is_jreg) begin
      if (reg_misalign) begin
        nxt = pc_q; // hold on bad target
      end else begin
        nxt       = rs_val_i;
        taken_o   = 1'b1;
        link_we_o = is_link;
      end
    end
  end

  assign misalign_o = is_jreg && reg_misalign;
  assign next_pc_o  = nxt;
  assign link_idx_o = REG_IDX_W'(LINK_REG);
  assign link_val_o = pc_plus;
  assign pc_o       = pc_q;

  bt_pc_reg #(.XLEN(XLEN)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .nxt_i  (nxt),
    .pc_o   (pc_q)
  );

  AST_JUMP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i == 3'd3 || ctl_i == 3'd4) |-> taken_o); // R6
  AST_LINK_ONLY_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (ctl_i == 3'd4 || ctl_i == 3'd6)); // R7
  AST_MISALIGN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (next_pc_o == pc_o && !taken_o && !link_we_o)); // R10
  AST_SEQ_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i == 3'd0 || ctl_i == 3'd7) |-> (!taken_o && next_pc_o == pc_o + STEP_BYTES)); // R5
  AST_REG_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && (ctl_i == 3'd5 || ctl_i == 3'd6)) |-> next_pc_o == rs_val_i); // R8
endmodule

// File: tb/br_target_unit_tb_top.sv
module br_target_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [2:0]  ctl = 3'd0;
  logic [25:0] off = '0;
  logic [31:0] rs = '0;
  logic [31:0] tst = '0;
  logic [31:0] pc, npc, lval;
  logic        taken, mis, lwe;
  logic [4:0]  lidx;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  br_target_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .ctl_i(ctl), .off_i(off),
    .rs_val_i(rs), .test_val_i(tst), .pc_o(pc), .next_pc_o(npc),
    .taken_o(taken), .misalign_o(mis), .link_we_o(lwe), .link_idx_o(lidx),
    .link_val_o(lval)
  );

  function automatic logic [31:0] sx16(logic [25:0] o);
    return {{16{o[15]}}, o[15:0]};
  endfunction
  function automatic logic [31:0] sx26(logic [25:0] o);
    return {{6{o[25]}}, o};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, settle, then compare before next rising edge
  task automatic apply(logic [2:0] c, logic [25:0] o, logic [31:0] r, logic [31:0] t);
    @(negedge clk);
    ctl = c; off = o; rs = r; tst = t; step = 1'b0;
    #2;
  endtask

  task automatic do_step;
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    #2;
  endtask

  task automatic set_pc(logic [31:0] v);
    apply(3'd5, '0, v, '0);
    do_step();
  endtask

  task automatic t_reset;
    chk("R1 pc after reset", pc, 32'h0);
  endtask

  task automatic t_seq;
    set_pc(32'h0000_1000);
    chk("R2 pc loaded by step", pc, 32'h0000_1000);
    apply(3'd0, 26'h3FF_FFFF, 32'h5, 32'h0);
    chk("R5 seq next", npc, 32'h0000_1004);
    chk("R5 seq taken", {31'b0, taken}, 32'h0);
    chk("R5 seq link", {31'b0, lwe}, 32'h0);
    apply(3'd7, 26'h123_4567, 32'h8, 32'h0);
    chk("R5 reserved next", npc, 32'h0000_1004);
    chk("R5 reserved taken", {31'b0, taken}, 32'h0);
    do_step();
    chk("R2 step seq", pc, 32'h0000_1004);
  endtask

  task automatic t_hold;
    logic [31:0] p0 = pc;
    apply(3'd3, 26'h000_0100, '0, '0);
    @(negedge clk); #2;
    chk("R2 hold without step", pc, p0);
  endtask

  task automatic t_beqz;
    set_pc(32'h0000_2000);
    apply(3'd1, 26'h3FF_0040, '0, 32'h0);
    chk("R3 beqz taken next", npc, 32'h0000_2004 + sx16(26'h0040));
    chk("R3 beqz taken flag", {31'b0, taken}, 32'h1);
    apply(3'd1, 26'h000_FFF0, '0, 32'h0);
    chk("R3 beqz negative", npc, 32'h0000_2004 + sx16(26'h0FFF0));
    apply(3'd1, 26'h000_0040, '0, 32'h8000_0000);
    chk("R3 beqz not taken next", npc, 32'h0000_2004);
    chk("R3 beqz not taken flag", {31'b0, taken}, 32'h0);
    apply(3'd1, 26'h000_0040, '0, 32'h0);
    do_step();
    chk("R3 beqz stepped pc", pc, 32'h0000_2044);
  endtask

  task automatic t_bnez;
    set_pc(32'h0000_3000);
    apply(3'd2, 26'h000_8000, '0, 32'h0000_0001);
    chk("R4 bnez taken next", npc, 32'h0000_3004 + sx16(26'h8000));
    chk("R4 bnez taken flag", {31'b0, taken}, 32'h1);
    apply(3'd2, 26'h000_8000, '0, 32'h0);
    chk("R4 bnez not taken next", npc, 32'h0000_3004);
    chk("R5 bnez not taken link", {31'b0, lwe}, 32'h0);
  endtask

  task automatic t_jump;
    set_pc(32'h0000_4000);
    apply(3'd3, 26'h100_0000, '0, '0);
    chk("R6 j next", npc, 32'h0000_4004 + sx26(26'h100_0000));
    chk("R6 j taken", {31'b0, taken}, 32'h1);
    chk("R6 j no link", {31'b0, lwe}, 32'h0);
  endtask

  task automatic t_jal;
    set_pc(32'h0000_5000);
    apply(3'd4, 26'h3FF_FF00, '0, '0);
    chk("R7 jal next", npc, 32'h0000_5004 + sx26(26'h3FF_FF00));
    chk("R7 jal link we", {31'b0, lwe}, 32'h1);
    chk("R7 jal link idx", {27'b0, lidx}, 32'd31);
    chk("R7 jal link val", lval, 32'h0000_5004);
  endtask

  task automatic t_jr;
    set_pc(32'h0000_6000);
    apply(3'd5, '0, 32'h0ABC_DEF0, '0);
    chk("R8 jr next", npc, 32'h0ABC_DEF0);
    chk("R8 jr taken", {31'b0, taken}, 32'h1);
    chk("R8 jr no link", {31'b0, lwe}, 32'h0);
    chk("R10 jr aligned flag", {31'b0, mis}, 32'h0);
  endtask

  task automatic t_jalr;
    set_pc(32'h0000_7000);
    apply(3'd6, '0, 32'h0000_0100, '0);
    chk("R9 jalr next", npc, 32'h0000_0100);
    chk("R9 jalr link we", {31'b0, lwe}, 32'h1);
    chk("R9 jalr link idx", {27'b0, lidx}, 32'd31);
    chk("R9 jalr link val", lval, 32'h0000_7004);
    do_step();
    chk("R9 jalr stepped pc", pc, 32'h0000_0100);
  endtask

  task automatic t_misalign;
    set_pc(32'h0000_8000);
    for (int lo = 1; lo < 4; lo++) begin
      apply((lo == 2) ? 3'd6 : 3'd5, '0, 32'h0000_9000 | 32'(lo), '0);
      chk("R10 misalign flag", {31'b0, mis}, 32'h1);
      chk("R10 misalign next", npc, 32'h0000_8000);
      chk("R10 misalign taken", {31'b0, taken}, 32'h0);
      chk("R10 misalign link", {31'b0, lwe}, 32'h0);
    end
    apply(3'd6, '0, 32'h0000_9003, '0);
    do_step();
    chk("R10 misalign pc held", pc, 32'h0000_8000);
  endtask

  task automatic t_bounds;
    set_pc(32'h1000_0000);
    apply(3'd3, 26'h200_0000, '0, '0);
    chk("R11 min offset", npc, 32'h1000_0004 - 32'h0200_0000);
    apply(3'd4, 26'h1FF_FFFF, '0, '0);
    chk("R11 max offset", npc, 32'h1000_0004 + 32'h01FF_FFFF);
    set_pc(32'hFFFF_FFFC);
    apply(3'd0, '0, '0, '0);
    chk("R11 wrap seq", npc, 32'h0);
    apply(3'd3, 26'h000_0010, '0, '0);
    chk("R11 wrap jump", npc, 32'h0000_0010);
    chk("R11 wrap link val", lval, 32'h0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); #2;
    t_reset();
    t_seq();
    t_hold();
    t_beqz();
    t_bnez();
    t_jump();
    t_jal();
    t_jr();
    t_jalr();
    t_misalign();
    t_bounds();
    finish_run();
  end
endmodule